// File: doc/BRIEF.md
# Programmable Clock Divider and Reset Sequencer

This block turns one reference clock into a bank of derived clocks and a small set of bus resets. Each clock lane divides the reference by an integer from 1 to 128. The ratio comes from a register that software writes at run time. A lane that is set to divide-by-1 hands the reference clock straight through. Any other ratio produces a registered square wave whose rising edge lines up with a rising edge of the reference.

Each reset output is tied, through a register, to one of the clock lanes. Software can force a reset on at any moment, and it turns on without waiting for a clock. When software lets a reset go, it turns off in step with its chosen lane clock, after two rising edges of that clock. At power-on every ratio is 1 and every reset is held, and they stay that way until software writes new values.

Configuration is a plain write port with no back-pressure. The block takes one register write on every reference edge where the write enable is high.

Top module: `clkrst_gen`

## Requirements
- R1: Each clock lane `k` (0 to 15) with ratio N of 2 or more toggles with a period of exactly N reference cycles.
- R2: For N of 2 or more, the lane output is high for floor(N/2) reference cycles and low for the rest of the period. The high phase begins at a rising reference edge.
- R3: With ratio 1, the lane output equals the reference clock: high in the first half of each reference cycle and low in the second half.
- R4: A ratio written as 0 acts as 1. A ratio written above 128 acts as 128.
- R5: A new ratio takes effect only when the lane finishes its current period. That period runs to its end with the old high and low lengths.
- R6: Reset control word: bit 0 is the hold bit, where 1 means asserted, and bits 7:4 select the lane clock. Setting hold drives the reset output high in the same reference cycle that captures the write, with no lane-clock edge needed.
- R7: After hold is cleared, the reset output stays high through the first rising edge of the selected lane clock. It goes low at the second rising edge.
- R8: While `rst_n` is low, and afterwards until software writes, every ratio is 1, every hold bit is 1 with select 0, and every reset output is high.
- R9: Address map: addresses 0 to 15 write the ratio of the lane with that index. Addresses 16 to 19 write the control word of reset `addr-16`. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_we | input | 1 | Register write strobe, sampled on rising `clk_ref` |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 8 | Register write data |
| clk_out | output | 16 | Derived clocks, one per lane |
| rst_out | output | 4 | Bus resets, active high |

## Verification
The bench goes after the ratio edges: 0, 1, 2, 3, 128 and a value above 128. A wrong clamp shows up as a missing output or a period that is too long or too short. Odd ratios test the floor rule for the high phase; an off-by-one there gives a duty cycle longer by one cycle. A ratio written in the middle of a period must not cut the period short. A divider that loads at once would produce a short runt phase, and the bench catches it by comparing every sample of the wave. For resets, the bench aims the release write away from lane edges and counts lane rising edges. A reset that drops after one edge, or after three, fails. So does an assertion that waits for a lane edge, or an alias of an unmapped address onto a real register.

// File: rtl/clkrst_pkg.sv
`timescale 1ns/1ps
package clkrst_pkg;
  localparam int RATIO_W   = 8;
  localparam int MAX_RATIO = 128;
  localparam int CNT_W     = $clog2(MAX_RATIO);
  localparam int SEL_W     = 4;
  localparam int DATA_W    = 8;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             hold;
  } rst_ctl_t;

  function automatic logic [RATIO_W-1:0] clamp_ratio(input logic [RATIO_W-1:0] v);
    if (v == '0) return RATIO_W'(1);
    if (v > RATIO_W'(MAX_RATIO)) return RATIO_W'(MAX_RATIO);
    return v;
  endfunction
endpackage

// File: rtl/clkrst_cfg.sv
`timescale 1ns/1ps
module clkrst_cfg
  import clkrst_pkg::*;
#(
  parameter int NUM_CLK = 16,
  parameter int NUM_RST = 4,
  parameter int ADDR_W  = 5
) (
  input  logic                              clk_ref,
  input  logic                              rst_n,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  output logic [NUM_CLK-1:0][RATIO_W-1:0]   ratio_o,
  output rst_ctl_t [NUM_RST-1:0]            ctl_o
);
  localparam int RST_BASE = NUM_CLK;

  for (genvar k = 0; k < NUM_CLK; k++) begin : g_ratio
    logic hit;
    assign hit = we_i && (addr_i == ADDR_W'(k));
    always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n)   ratio_o[k] <= RATIO_W'(1);
      else if (hit) ratio_o[k] <= clamp_ratio(wdata_i[RATIO_W-1:0]);
    end

    p_ratio_legal_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (ratio_o[k] >= RATIO_W'(1)) && (ratio_o[k] <= RATIO_W'(MAX_RATIO)));
  end

  for (genvar r = 0; r < NUM_RST; r++) begin : g_ctl
    logic hit;
    assign hit = we_i && (addr_i == ADDR_W'(RST_BASE + r));
    always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
        ctl_o[r].hold <= 1'b1;
        ctl_o[r].sel  <= '0;
      end else if (hit) begin
        ctl_o[r].hold <= wdata_i[0];
        ctl_o[r].sel  <= wdata_i[4 +: SEL_W];
      end
    end
  end
endmodule

// File: rtl/clkrst_lane.sv
`timescale 1ns/1ps
module clkrst_lane
  import clkrst_pkg::*;
(
  input  logic               clk_ref,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               clk_o
);
  logic [RATIO_W-1:0] cur_n, n_nxt, half;
  logic [CNT_W-1:0]   cnt, cnt_nxt;
  logic               wrap, div_q, byp_q, div_d;

  assign wrap    = ({1'b0, cnt} == (cur_n - RATIO_W'(1)));
  assign n_nxt   = wrap ? ratio_i : cur_n;
  assign cnt_nxt = wrap ? '0 : cnt + CNT_W'(1);
  assign half    = n_nxt >> 1;
  assign div_d   = ({1'b0, cnt_nxt} < half);

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      cur_n <= RATIO_W'(1);
      cnt   <= '0;
      div_q <= 1'b0;
      byp_q <= 1'b1;
    end else begin
      cur_n <= n_nxt;
      cnt   <= cnt_nxt;
      div_q <= div_d;
      byp_q <= (n_nxt == RATIO_W'(1));
    end
  end

  assign clk_o = byp_q ? clk_ref : div_q;

  p_cnt_below_ratio_r1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ({1'b0, cnt} < cur_n));

  p_load_at_wrap_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (cur_n != $past(cur_n)) |-> ({1'b0, $past(cnt)} == ($past(cur_n) - RATIO_W'(1))));

  p_rise_at_start_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(div_q) |-> (cnt == '0));
endmodule

// File: rtl/clkrst_sync.sv
`timescale 1ns/1ps
module clkrst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_i,
  output logic rst_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) chain <= '1;
    else        chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign rst_o = chain[STAGES-1];
endmodule

// File: rtl/clkrst_gen.sv
`timescale 1ns/1ps
module clkrst_gen
  import clkrst_pkg::*;
#(
  parameter int NUM_CLK = 16,
  parameter int NUM_RST = 4,
  parameter int ADDR_W  = 5
) (
  input  logic               clk_ref,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [NUM_CLK-1:0] clk_out,
  output logic [NUM_RST-1:0] rst_out
);
  logic [NUM_CLK-1:0][RATIO_W-1:0] ratio;
  rst_ctl_t [NUM_RST-1:0]          ctl;

  clkrst_cfg #(.NUM_CLK(NUM_CLK), .NUM_RST(NUM_RST), .ADDR_W(ADDR_W)) u_cfg (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .we_i    (cfg_we),
    .addr_i  (cfg_addr),
    .wdata_i (cfg_wdata),
    .ratio_o (ratio),
    .ctl_o   (ctl)
  );

  for (genvar k = 0; k < NUM_CLK; k++) begin : g_lane
    clkrst_lane u_lane (
      .clk_ref (clk_ref),
      .rst_n   (rst_n),
      .ratio_i (ratio[k]),
      .clk_o   (clk_out[k])
    );
  end

  for (genvar r = 0; r < NUM_RST; r++) begin : g_rst
    logic sel_clk, arst;
    assign sel_clk = (int'(ctl[r].sel) < NUM_CLK) ? clk_out[ctl[r].sel] : clk_out[0];
    assign arst    = ~rst_n | ctl[r].hold;

    clkrst_sync #(.STAGES(2)) u_sync (
      .clk_i  (sel_clk),
      .arst_i (arst),
      .rst_o  (rst_out[r])
    );

    p_async_assert_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
      ctl[r].hold |-> rst_out[r]);
  end
endmodule

// File: tb/clkrst_gen_test.sv
`timescale 1ns/1ps
module clkrst_gen_test;
  logic        clk_ref = 1'b0;
  logic        rst_n   = 1'b0;
  logic        cfg_we  = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [15:0] clk_out;
  logic [3:0]  rst_out;

  int n_chk = 0;
  int n_bad = 0;
  int ratio_m [16];

  always #10 clk_ref = ~clk_ref;

  clkrst_gen uut (
    .clk_ref (clk_ref), .rst_n (rst_n), .cfg_we (cfg_we),
    .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
    .clk_out (clk_out), .rst_out (rst_out)
  );

  function automatic int exp_ratio(input int w);
    if (w == 0) return 1;
    if (w > 128) return 128;
    return w;
  endfunction

  function automatic logic exp_level(input int j, input int n);
    return (j % n) < (n / 2);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_ref); #5;
  endtask

  task automatic cfg_write(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 8'(d);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic sync_rise(input int lane, output bit ok);
    logic prev;
    ok = 0;
    prev = clk_out[lane];
    for (int t = 0; t < 300; t++) begin
      tick();
      if (!prev && clk_out[lane]) begin ok = 1; break; end
      prev = clk_out[lane];
    end
  endtask

  task automatic measure(input int lane, input int n, input int wait_n, input string req);
    bit ok;
    int bad_j;
    repeat (wait_n + 2) tick();
    bad_j = -1;
    if (n == 1) begin
      for (int k = 0; k < 4; k++) begin
        if (clk_out[lane] !== 1'b1 && bad_j < 0) bad_j = 2 * k;
        #10;
        if (clk_out[lane] !== 1'b0 && bad_j < 0) bad_j = 2 * k + 1;
        tick();
      end
      chk({req, " bypass follows reference"}, bad_j, -1);
      return;
    end
    sync_rise(lane, ok);
    chk({req, " rising edge found"}, int'(ok), 1);
    for (int j = 1; j < 3 * n; j++) begin
      tick();
      if (clk_out[lane] !== exp_level(j, n) && bad_j < 0) bad_j = j;
    end
    chk({req, " waveform first bad sample"}, bad_j, -1);
  endtask

  task automatic set_ratio(input int lane, input int w, input string req);
    int old, n;
    old = ratio_m[lane];
    n = exp_ratio(w);
    cfg_write(lane, w);
    ratio_m[lane] = n;
    measure(lane, n, old, req);
  endtask

  initial begin
    #(20ns * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit ok;
    int lane, w;
    for (int i = 0; i < 16; i++) ratio_m[i] = 1;
    void'($urandom(32'd4242));

    repeat (3) @(posedge clk_ref);
    #5;
    chk("R8 resets high during rst_n", int'(rst_out), 15);
    rst_n = 1'b1;
    repeat (20) tick();
    chk("R8 resets held after power-on", int'(rst_out), 15);
    measure(0, 1, 0, "R8 lane0 default ratio 1");
    measure(15, 1, 0, "R8 lane15 default ratio 1");

    // directed ratio corners
    set_ratio(4, 2, "R1 R2 ratio 2");
    set_ratio(5, 3, "R2 odd ratio 3");
    set_ratio(6, 128, "R1 ratio 128");
    set_ratio(7, 0, "R4 zero acts as 1");
    set_ratio(8, 200, "R4 clamp to 128");
    set_ratio(6, 1, "R3 back to bypass");
    set_ratio(9, 7, "R2 odd ratio 7");

    // random ratios
    for (int i = 0; i < 10; i++) begin
      lane = int'($urandom % 16);
      w = int'($urandom % 140);
      set_ratio(lane, w, "R1 R2 R4 random ratio");
    end

    // mid-period change completes old period
    set_ratio(3, 8, "R1 ratio 8");
    sync_rise(3, ok);
    chk("R5 sync", int'(ok), 1);
    begin
      int bad_j;
      bad_j = -1;
      tick();
      if (clk_out[3] !== 1'b1) bad_j = 1;
      cfg_write(3, 4);
      ratio_m[3] = 4;
      for (int j = 2; j < 24; j++) begin
        if (j > 2) tick();
        if (clk_out[3] !== ((j < 8) ? (j < 4) : (((j - 8) % 4) < 2)) && bad_j < 0) bad_j = j;
      end
      chk("R5 no runt on ratio change", bad_j, -1);
    end

    // reset 0 release on lane 2 at ratio 8
    set_ratio(2, 8, "R1 ratio 8 lane2");
    sync_rise(2, ok);
    cfg_write(16, 8'h20);
    begin
      int bad_j;
      bad_j = -1;
      for (int j = 1; j <= 16; j++) begin
        if (j > 1) tick();
        if (rst_out[0] !== (j < 16) && bad_j < 0) bad_j = j;
      end
      chk("R7 release at second lane edge (ratio 8)", bad_j, -1);
    end
    chk("R8 other resets still held", int'(rst_out[3:1]), 7);

    // reset 1 release on lane 1 at ratio 2
    set_ratio(1, 2, "R1 ratio 2 lane1");
    sync_rise(1, ok);
    cfg_write(17, 8'h10);
    begin
      int bad_j;
      bad_j = -1;
      for (int j = 1; j <= 4; j++) begin
        if (j > 1) tick();
        if (rst_out[1] !== (j < 4) && bad_j < 0) bad_j = j;
      end
      chk("R7 release at second lane edge (ratio 2)", bad_j, -1);
    end

    // asynchronous assertion
    cfg_write(16, 8'h21);
    chk("R6 hold asserts reset without lane edge", int'(rst_out[0]), 1);
    cfg_write(17, 8'h11);
    chk("R6 hold asserts reset 1", int'(rst_out[1]), 1);
    cfg_write(17, 8'h10);
    repeat (8) tick();
    chk("R7 reset 1 released again", int'(rst_out[1]), 0);

    // unmapped addresses
    set_ratio(15, 5, "R1 ratio 5 lane15");
    cfg_write(20, 8'h00);
    cfg_write(31, 8'h00);
    repeat (40) tick();
    chk("R9 addr 20 ignored, reset 0 held", int'(rst_out[0]), 1);
    chk("R9 reset 1 unaffected", int'(rst_out[1]), 0);
    measure(15, 5, 0, "R9 addr 31 ignored, lane15 ratio 5");

    // power-on reset mid-run
    rst_n = 1'b0;
    #3;
    chk("R8 reset outputs high at once", int'(rst_out), 15);
    tick();
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) ratio_m[i] = 1;
    repeat (20) tick();
    chk("R8 resets held after second power-on", int'(rst_out), 15);
    measure(2, 1, 0, "R8 ratio back to 1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule